// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a single-cycle host request port and an external asynchronous static RAM with a 16-bit data bus split into two byte lanes. The host presents a read or a write while `host_ready` is high. The controller latches it and plays out the memory's control strobes as a fixed sequence of phases. Each phase is a whole number of clock cycles, worked out when the design is elaborated from nanosecond timing parameters and the clock period `CLK_NS`. Each phase count is the nanosecond figure divided by the period and rounded up, and is never less than one cycle.

A read holds chip select, output enable, address and byte enables until the slowest access time has passed. It then captures the word, returns it with a one-cycle `host_rvalid`, and deasserts everything for a bus-turnaround phase. A write raises select and address first, then pulls write enable low and drives data for a pulse phase. It then raises write enable while still driving data for a recovery phase. Only one access is in flight at a time.

States: `ST_IDLE` (waiting, selects deasserted), `ST_RD_ACCESS` (read strobes held), `ST_RD_TURN` (bus released after a read), `ST_WR_SETUP` (address and select up, write enable high), `ST_WR_PULSE` (write enable low, data driven), `ST_WR_RECOVER` (write enable high, data held). Transitions, each taken when the current phase's counter expires unless noted:
- `ST_IDLE` → `ST_RD_ACCESS` on a request with `host_we`=0, taken in the same cycle without waiting on a counter.
- `ST_IDLE` → `ST_WR_SETUP` on a request with `host_we`=1, also taken without waiting on a counter.
- `ST_RD_ACCESS` → `ST_RD_TURN`, capturing the read data.
- `ST_RD_TURN` → `ST_IDLE`.
- `ST_WR_SETUP` → `ST_WR_PULSE`.
- `ST_WR_PULSE` → `ST_WR_RECOVER`.
- `ST_WR_RECOVER` → `ST_IDLE`.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, and in every cycle in which `host_ready` is high, the memory pins sit in their idle levels: `mem_cs_n`=1, `mem_cs`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0. `host_rvalid` is 0 after reset.
- R2: An accepted read holds select, `mem_oe_n`=0, address and byte enables for RD = max over {70, 70, 70, 40} ns of ceil(t/CLK_NS) cycles, then captures `mem_rdata`. The read's `host_rvalid` is first high in the (RD+1)-th cycle after the accepting edge.
- R3: Bit 0 of `host_be` selects the low byte (data bits 7:0) and bit 1 selects the high byte (bits 15:8). The host byte enables are active high; the memory byte enables are active low. A lane not enabled on a read returns zero in `host_rdata`.
- R4: `mem_dq_oe` is never high while `mem_oe_n` is low. After `mem_oe_n` rises, at least TURN = ceil(max(20, 25)/CLK_NS) cycles pass before `mem_dq_oe` next rises.
- R5: A write runs for 1 setup cycle with `mem_we_n` high, then PULSE = ceil(max(50, 60, 30)/CLK_NS) cycles with `mem_we_n` low and stable data driven, then REC = max(1, ceil(70/CLK_NS) − 1 − PULSE) cycles with `mem_we_n` high and data still driven. `host_ready` returns 2 + PULSE + REC cycles after the accepting edge. `mem_oe_n` stays high throughout.
- R6: `mem_we_n` is low only while both selects are active, and the selects have been active for at least ceil(60/CLK_NS) cycles when `mem_we_n` rises.
- R7: A write changes only the lanes whose `host_be` bit is 1. With `host_be`=0 it changes nothing.
- R8: `host_ready` is high only in `ST_IDLE`. A request held while the block is busy is neither lost nor started early: it is accepted at the first edge at which `host_ready` is high, and `host_ready` is low in the next cycle.
- R9: `host_rvalid` is never high in two consecutive cycles, and `host_rdata` keeps the last read word until the next read completes.
- R10: Address and memory byte enables do not change while the selects are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Request; accepted when `host_ready` is high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 19 | Word address |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Active-high lane enables (bit 0 low byte) |
| host_ready | output | 1 | Block idle, request will be accepted |
| host_rvalid | output | 1 | One-cycle read-data strobe |
| host_rdata | output | 16 | Captured read word, disabled lanes zero |
| mem_addr | output | 19 | Memory address |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_be_n | output | 2 | Active-low byte enables |
| mem_wdata | output | 16 | Write data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_wdata` |
| mem_rdata | input | 16 | Data from the memory |

## Verification
Two events can fall in the same cycle: the end of a read, when `host_rvalid` pulses, and the arrival of the host's next request, a write. The bench raises a write request in the very cycle in which it sees `host_rvalid` and holds it there. It then judges three things: that `host_ready` stays low for exactly TURN cycles with write enable untouched; that the write is accepted and completes with the gap between output-enable release and data drive of at least TURN cycles; and that a later read returns the written word. A paired behavioural memory returns garbage until the access time has elapsed, and its monitors count strobe widths and overlaps in every cycle of an address and lane sweep.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_RD_ACCESS  = 3'd1,
        ST_RD_TURN    = 3'd2,
        ST_WR_SETUP   = 3'd3,
        ST_WR_PULSE   = 3'd4,
        ST_WR_RECOVER = 3'd5
    } sram_state_e;

    // Cycles needed to cover t_ns, rounded up, never below one cycle.
    function automatic int unsigned ns_to_cyc(input int unsigned t_ns,
                                              input int unsigned clk_ns);
        int unsigned c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a,
                                         input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_cmd_latch.sv
module sram_cmd_latch #(
    parameter int unsigned AW = 19,
    parameter int unsigned DW = 16,
    parameter int unsigned BW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] wdata_in,
    input  logic [BW-1:0] be_in,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic [BW-1:0] be_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (capture) begin
            addr_q  <= addr_in;
            wdata_q <= wdata_in;
            be_q    <= be_in;
        end
    end

endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture #(
    parameter int unsigned DW = 16,
    parameter int unsigned BW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [BW-1:0] lane_en,
    input  logic [DW-1:0] mem_rdata,
    output logic          rvalid,
    output logic [DW-1:0] rdata
);

    localparam int unsigned LANE_W = DW / BW;

    logic [DW-1:0] masked;

    // Lanes the access did not enable float on the memory side; force zero.
    for (genvar g = 0; g < BW; g++) begin : g_lane
        assign masked[g*LANE_W +: LANE_W] =
            lane_en[g] ? mem_rdata[g*LANE_W +: LANE_W] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= capture;
            if (capture) begin
                rdata <= masked;
            end
        end
    end

endmodule

// File: rtl/sram_strobe_decode.sv
module sram_strobe_decode
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned AW = 19,
    parameter int unsigned DW = 16,
    parameter int unsigned BW = 2
) (
    input  sram_state_e   state,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    input  logic [BW-1:0] cmd_be,
    output logic          host_ready,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs_n,
    output logic          mem_cs,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [BW-1:0] mem_be_n,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_dq_oe
);

    assign mem_addr  = cmd_addr;
    assign mem_wdata = cmd_wdata;

    always_comb begin
        host_ready = 1'b0;
        mem_cs_n   = 1'b1;
        mem_cs     = 1'b0;
        mem_we_n   = 1'b1;
        mem_oe_n   = 1'b1;
        mem_be_n   = '1;
        mem_dq_oe  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                host_ready = 1'b1;
            end
            ST_RD_ACCESS: begin
                mem_cs_n = 1'b0;
                mem_cs   = 1'b1;
                mem_oe_n = 1'b0;
                mem_be_n = ~cmd_be;
            end
            ST_RD_TURN: begin
                // everything released; memory outputs drain
            end
            ST_WR_SETUP: begin
                mem_cs_n = 1'b0;
                mem_cs   = 1'b1;
                mem_be_n = ~cmd_be;
            end
            ST_WR_PULSE: begin
                mem_cs_n  = 1'b0;
                mem_cs    = 1'b1;
                mem_we_n  = 1'b0;
                mem_be_n  = ~cmd_be;
                mem_dq_oe = 1'b1;
            end
            ST_WR_RECOVER: begin
                mem_cs_n  = 1'b0;
                mem_cs    = 1'b1;
                mem_be_n  = ~cmd_be;
                mem_dq_oe = 1'b1;
            end
            default: begin
                host_ready = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned AW     = 19,
    parameter int unsigned DW     = 16,
    parameter int unsigned BW     = 2,
    parameter int unsigned CLK_NS = 10,
    parameter int unsigned T_RC   = 70,
    parameter int unsigned T_AA   = 70,
    parameter int unsigned T_ACS  = 70,
    parameter int unsigned T_OE   = 40,
    parameter int unsigned T_OHZ  = 20,
    parameter int unsigned T_CHZ  = 20,
    parameter int unsigned T_WHZ  = 25,
    parameter int unsigned T_WC   = 70,
    parameter int unsigned T_CW   = 60,
    parameter int unsigned T_AW   = 60,
    parameter int unsigned T_BW   = 60,
    parameter int unsigned T_WP   = 50,
    parameter int unsigned T_DW   = 30,
    parameter int unsigned T_AS   = 0,
    parameter int unsigned T_WR   = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_req,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic [BW-1:0] host_be,
    output logic          host_ready,
    output logic          host_rvalid,
    output logic [DW-1:0] host_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs_n,
    output logic          mem_cs,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [BW-1:0] mem_be_n,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_rdata
);

    // ---- phase lengths in cycles ----
    localparam int unsigned RD_CYC   = umax(umax(ns_to_cyc(T_RC, CLK_NS), ns_to_cyc(T_AA, CLK_NS)),
                                            umax(ns_to_cyc(T_ACS, CLK_NS), ns_to_cyc(T_OE, CLK_NS)));
    localparam int unsigned TURN_CYC = umax(umax(ns_to_cyc(T_OHZ, CLK_NS), ns_to_cyc(T_CHZ, CLK_NS)),
                                            ns_to_cyc(T_WHZ, CLK_NS));
    localparam int unsigned SETUP_CYC = ns_to_cyc(T_AS, CLK_NS);
    localparam int unsigned PULSE_CYC = umax(umax(ns_to_cyc(T_WP, CLK_NS), ns_to_cyc(T_DW, CLK_NS)),
                                             umax(ns_to_cyc(T_CW, CLK_NS),
                                                  umax(ns_to_cyc(T_AW, CLK_NS), ns_to_cyc(T_BW, CLK_NS))));
    localparam int unsigned WC_CYC    = ns_to_cyc(T_WC, CLK_NS);
    localparam int unsigned REC_CYC   = umax(ns_to_cyc(T_WR, CLK_NS),
                                             (WC_CYC > SETUP_CYC + PULSE_CYC) ?
                                             (WC_CYC - SETUP_CYC - PULSE_CYC) : 1);
    localparam int unsigned MAX_DUR   = umax(umax(RD_CYC, TURN_CYC),
                                             umax(umax(SETUP_CYC, PULSE_CYC), REC_CYC));
    localparam int unsigned CNT_W     = $clog2(MAX_DUR + 1);

    localparam logic [CNT_W-1:0] RD_V    = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_V  = CNT_W'(TURN_CYC - 1);
    localparam logic [CNT_W-1:0] SETUP_V = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_V = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] REC_V   = CNT_W'(REC_CYC - 1);

    sram_state_e      state_q, state_d;
    logic             tmr_load, tmr_expired;
    logic [CNT_W-1:0] tmr_val;
    logic             cmd_take, rd_take;
    logic [AW-1:0]    cmd_addr;
    logic [DW-1:0]    cmd_wdata;
    logic [BW-1:0]    cmd_be;

    // ---- state register ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---- next state and phase loads ----
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cmd_take = 1'b0;
        rd_take  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (host_req) begin
                    cmd_take = 1'b1;
                    tmr_load = 1'b1;
                    if (host_we) begin
                        state_d = ST_WR_SETUP;
                        tmr_val = SETUP_V;
                    end else begin
                        state_d = ST_RD_ACCESS;
                        tmr_val = RD_V;
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (tmr_expired) begin
                    rd_take  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TURN_V;
                    state_d  = ST_RD_TURN;
                end
            end
            ST_RD_TURN: begin
                if (tmr_expired) begin
                    state_d = ST_IDLE;
                end
            end
            ST_WR_SETUP: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    tmr_val  = PULSE_V;
                    state_d  = ST_WR_PULSE;
                end
            end
            ST_WR_PULSE: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    tmr_val  = REC_V;
                    state_d  = ST_WR_RECOVER;
                end
            end
            ST_WR_RECOVER: begin
                if (tmr_expired) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_cmd_latch #(.AW(AW), .DW(DW), .BW(BW)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (cmd_take),
        .addr_in  (host_addr),
        .wdata_in (host_wdata),
        .be_in    (host_be),
        .addr_q   (cmd_addr),
        .wdata_q  (cmd_wdata),
        .be_q     (cmd_be)
    );

    sram_read_capture #(.DW(DW), .BW(BW)) u_rcap (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (rd_take),
        .lane_en   (cmd_be),
        .mem_rdata (mem_rdata),
        .rvalid    (host_rvalid),
        .rdata     (host_rdata)
    );

    sram_strobe_decode #(.AW(AW), .DW(DW), .BW(BW)) u_dec (
        .state      (state_q),
        .cmd_addr   (cmd_addr),
        .cmd_wdata  (cmd_wdata),
        .cmd_be     (cmd_be),
        .host_ready (host_ready),
        .mem_addr   (mem_addr),
        .mem_cs_n   (mem_cs_n),
        .mem_cs     (mem_cs),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_be_n   (mem_be_n),
        .mem_wdata  (mem_wdata),
        .mem_dq_oe  (mem_dq_oe)
    );

    // ---- assertions ----
    // Cycles since output enable was last released, saturating at TURN_CYC.
    logic [CNT_W-1:0] gap_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt <= CNT_W'(TURN_CYC);
        end else if (!mem_oe_n) begin
            gap_cnt <= '0;
        end else if (gap_cnt < CNT_W'(TURN_CYC)) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> (mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe));

    a_r2_rvalid_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> $past(!mem_oe_n && !mem_cs_n));

    a_r4_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    a_r4_turn_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (gap_cnt >= CNT_W'(TURN_CYC)));

    a_r5_data_covers_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && $past(mem_dq_oe)));

    a_r5_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    a_r6_we_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && mem_cs && $past(!mem_cs_n)));

    a_r8_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_ready) |=> !host_ready);

    a_r9_rvalid_single: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |=> !host_rvalid);

    a_r10_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_be_n)));

endmodule

// File: tb/tb_sram_strobe_ctrl.sv
`timescale 1ns/1ps
module tb_sram_strobe_ctrl;

    localparam int CLK_NS = 8;
    localparam int AW = 19;
    localparam int DW = 16;
    localparam int BW = 2;

    function automatic int cdiv(input int t);
        int c;
        c = (t + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int E_RD    = cdiv(70);
    localparam int E_TURN  = (cdiv(25) > cdiv(20)) ? cdiv(25) : cdiv(20);
    localparam int E_WP    = cdiv(50);
    localparam int E_CW    = cdiv(60);
    localparam int E_PULSE = (cdiv(60) > cdiv(50)) ? cdiv(60) : cdiv(50);
    localparam int E_REC   = (cdiv(70) - 1 - E_PULSE > 1) ? cdiv(70) - 1 - E_PULSE : 1;
    localparam int E_WLAT  = 2 + E_PULSE + E_REC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_req = 1'b0;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [BW-1:0] host_be = '0;
    logic          host_ready, host_rvalid;
    logic [DW-1:0] host_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [BW-1:0] mem_be_n;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;

    always #4 clk = ~clk;

    sram_strobe_ctrl #(.AW(AW), .DW(DW), .BW(BW), .CLK_NS(CLK_NS)) dut (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_be(host_be),
        .host_ready(host_ready), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n),
        .mem_wdata(mem_wdata), .mem_dq_oe(mem_dq_oe), .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // ---------------- behavioural memory ----------------
    logic [15:0] store [int];
    int          rd_age;
    logic [AW-1:0] rd_addr_q;
    logic        prev_we_low;
    logic [15:0] pend_data;
    logic [1:0]  pend_lane;

    wire sel     = !mem_cs_n && mem_cs;
    wire rd_cond = sel && !mem_oe_n && mem_we_n && (mem_be_n != 2'b11);

    function automatic logic [15:0] peek(input int a);
        return store.exists(a) ? store[a] : 16'h0000;
    endfunction

    always_comb begin
        logic [15:0] w;
        w = peek(int'(mem_addr));
        mem_rdata = 16'hDEAD;
        if (rd_cond && rd_age >= E_RD) begin
            mem_rdata[7:0]  = !mem_be_n[0] ? w[7:0]  : 8'hEE;
            mem_rdata[15:8] = !mem_be_n[1] ? w[15:8] : 8'hEE;
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            rd_age = 0;
            rd_addr_q = '0;
            prev_we_low = 1'b0;
            pend_lane = 2'b00;
            pend_data = '0;
        end else begin
            if (prev_we_low && mem_we_n) begin
                logic [15:0] w;
                w = peek(int'(mem_addr));
                if (pend_lane[0]) w[7:0] = pend_data[7:0];
                if (pend_lane[1]) w[15:8] = pend_data[15:8];
                store[int'(mem_addr)] = w;
                pend_lane = 2'b00;
            end
            if (sel && !mem_we_n && mem_dq_oe) begin
                if (!mem_be_n[0]) begin pend_data[7:0] = mem_wdata[7:0];   pend_lane[0] = 1'b1; end
                if (!mem_be_n[1]) begin pend_data[15:8] = mem_wdata[15:8]; pend_lane[1] = 1'b1; end
            end
            prev_we_low = sel && !mem_we_n;
            rd_age = (rd_cond && (rd_age == 0 || mem_addr == rd_addr_q)) ? rd_age + 1 : 0;
            rd_addr_q = mem_addr;
        end
    end

    // ---------------- strobe monitors ----------------
    int we_low_n = 0, sel_n = 0, oe_hi_n = 1000;
    logic m_prev_we_l = 1'b0, m_prev_sel = 1'b0, m_prev_dq = 1'b0, m_prev_rv = 1'b0;
    logic [AW-1:0] m_prev_addr = '0;
    logic [BW-1:0] m_prev_be = '1;
    logic [DW-1:0] m_prev_wd = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sel && m_prev_sel && (mem_addr != m_prev_addr || mem_be_n != m_prev_be))
                chk(0, "R10", "address/lanes moved under select", int'(mem_addr), int'(m_prev_addr));
            if (!mem_we_n && !sel)
                chk(0, "R6", "write enable outside select", 0, 1);
            if (mem_dq_oe && !mem_oe_n)
                chk(0, "R4", "data driven with output enable low", 1, 0);
            if (!mem_we_n && !mem_dq_oe)
                chk(0, "R5", "pulse without data drive", 0, 1);
            if (!mem_we_n && !mem_oe_n)
                chk(0, "R5", "output enable low during write", 0, 1);
            if (!mem_we_n && m_prev_we_l && mem_wdata != m_prev_wd)
                chk(0, "R5", "write data moved in pulse", int'(mem_wdata), int'(m_prev_wd));
            if (host_ready && (!mem_cs_n || mem_cs || !mem_we_n || !mem_oe_n || mem_dq_oe))
                chk(0, "R1", "strobes active while ready", 1, 0);
            if (host_rvalid && m_prev_rv)
                chk(0, "R9", "rvalid longer than one cycle", 2, 1);
            if (m_prev_we_l && mem_we_n) begin
                chk(we_low_n >= E_WP && we_low_n == E_PULSE, "R5", "write pulse cycles", we_low_n, E_PULSE);
                chk(sel_n >= E_CW, "R6", "select cycles before write end", sel_n, E_CW);
            end
            if (mem_dq_oe && !m_prev_dq)
                chk(oe_hi_n >= E_TURN, "R4", "turnaround before data drive", oe_hi_n, E_TURN);
            we_low_n = !mem_we_n ? we_low_n + 1 : 0;
            sel_n    = sel ? sel_n + 1 : 0;
            oe_hi_n  = mem_oe_n ? ((oe_hi_n < 1000) ? oe_hi_n + 1 : oe_hi_n) : 0;
            m_prev_we_l = !mem_we_n;
            m_prev_sel  = sel;
            m_prev_dq   = mem_dq_oe;
            m_prev_rv   = host_rvalid;
            m_prev_addr = mem_addr;
            m_prev_be   = mem_be_n;
            m_prev_wd   = mem_wdata;
        end
    end

    // ---------------- host side ----------------
    logic [15:0] shadow [int];

    function automatic logic [15:0] sh_get(input int a);
        return shadow.exists(a) ? shadow[a] : 16'h0000;
    endfunction

    function automatic logic [15:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] be);
        int lat;
        while (!host_ready) @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d; host_be = be;
        @(negedge clk);
        host_req = 1'b0;
        lat = 1;
        while (!host_ready) begin @(negedge clk); lat++; end
        chk(lat == E_WLAT, "R5", "write occupancy", lat, E_WLAT);
        shadow[int'(a)] = (sh_get(int'(a)) & ~lane_mask(be)) | (d & lane_mask(be));
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [1:0] be, output logic [15:0] d);
        int lat;
        while (!host_ready) @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_addr = a; host_be = be;
        @(negedge clk);
        host_req = 1'b0;
        lat = 1;
        while (!host_rvalid) begin @(negedge clk); lat++; end
        d = host_rdata;
        chk(lat == E_RD + 1, "R2", "read latency", lat, E_RD + 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", "run did not finish", 0, 1);
        summary();
        $finish;
    end

    initial begin
        logic [15:0] got, exp, last;
        logic [AW-1:0] a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(host_ready == 1'b1, "R1", "ready after reset", int'(host_ready), 1);
        chk(mem_cs_n == 1'b1, "R1", "cs_n after reset", int'(mem_cs_n), 1);
        chk(mem_cs == 1'b0, "R1", "cs after reset", int'(mem_cs), 0);
        chk(mem_we_n == 1'b1, "R1", "we_n after reset", int'(mem_we_n), 1);
        chk(mem_oe_n == 1'b1, "R1", "oe_n after reset", int'(mem_oe_n), 1);
        chk(mem_dq_oe == 1'b0, "R1", "dq_oe after reset", int'(mem_dq_oe), 0);
        chk(host_rvalid == 1'b0, "R1", "rvalid after reset", int'(host_rvalid), 0);

        // Sweep: zero, walking ones, all ones; every write lane set, every read lane set
        for (int idx = 0; idx <= AW + 1; idx++) begin
            if (idx == 0)            a = '0;
            else if (idx <= AW)      a = AW'(1) << (idx - 1);
            else                     a = '1;
            exp = 16'((int'(a) * 40503) ^ 32'h5A5A);
            do_write(a, exp, 2'b11);
            do_read(a, 2'b11, got);
            chk(got == sh_get(int'(a)), "R7", "full word readback", int'(got), int'(sh_get(int'(a))));
            for (int wbe = 0; wbe < 4; wbe++) begin
                last = got;
                do_write(a, ~exp ^ 16'(wbe * 16'h1111), 2'(wbe));
                chk(host_rdata == last, "R9", "rdata held across write", int'(host_rdata), int'(last));
                for (int rbe = 0; rbe < 4; rbe++) begin
                    do_read(a, 2'(rbe), got);
                    exp = sh_get(int'(a)) & lane_mask(2'(rbe));
                    if (rbe == 3)
                        chk(got == exp, "R7", "lane-limited write", int'(got), int'(exp));
                    else
                        chk(got == exp, "R3", "lane-masked read", int'(got), int'(exp));
                end
                exp = 16'((int'(a) * 40503) ^ 32'h5A5A);
            end
        end

        // Write request raised in the rvalid cycle of a read and held (R8, R4)
        while (!host_ready) @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_addr = 19'h12345; host_be = 2'b11;
        @(negedge clk);
        host_req = 1'b0;
        while (!host_rvalid) @(negedge clk);
        chk(host_rdata == sh_get(32'h12345), "R2", "read before overlap", int'(host_rdata), int'(sh_get(32'h12345)));
        host_req = 1'b1; host_we = 1'b1; host_addr = 19'h2AAAA; host_wdata = 16'hC3A5; host_be = 2'b11;
        chk(host_ready == 1'b0, "R8", "busy during rvalid", int'(host_ready), 0);
        begin
            int waits;
            waits = 0;
            while (!host_ready) begin
                if (!mem_we_n) chk(0, "R8", "write started while busy", 0, 1);
                @(negedge clk);
                waits++;
            end
            chk(waits == E_TURN, "R8", "cycles held before accept", waits, E_TURN);
        end
        @(negedge clk);
        chk(host_ready == 1'b0, "R8", "held request accepted", int'(host_ready), 0);
        host_req = 1'b0;
        shadow[32'h2AAAA] = 16'hC3A5;
        while (!host_ready) @(negedge clk);
        do_read(19'h2AAAA, 2'b11, got);
        chk(got == 16'hC3A5, "R8", "held write landed", int'(got), 16'hC3A5);

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule